// File: doc/BRIEF.md
# Cross-Shaped Adaptive Support Disparity Voter

This block serves a local stereo matcher. It picks the disparity for one centre pixel. The caller supplies two inputs: a square luminance window of the left image, centred on the pixel, and a wider strip of the right image that covers every candidate shift. For each image the block grows a cross-shaped support region around the centre. First a vertical arm grows from the centre. Then each pixel on that vertical arm grows a horizontal arm of its own. A pixel joins an arm while its luminance stays within a programmable delta of the pixel that anchors the arm.

The block tries 60 candidate disparities, one per clock cycle. For each one it builds the right-image region at the shifted position and intersects it with the left-image region. It then counts the pixels in the intersection whose left and right luminances agree within a match threshold. Once all counts are stored, a balanced comparison tree picks the disparity with the largest count. The block reports that disparity and its count with a one-cycle done pulse.

A request is one start pulse. The caller holds the windows and thresholds stable until done arrives, and pads the window at image borders.

Top module: `xsupport_agg`

## Requirements
- R1: After reset, done_o is 0, disp_o is 0 and count_o is 0.
- R2: An arm grows one pixel at a time away from its anchor. It includes a pixel only if that pixel and every pixel between it and the anchor differ from the anchor's luminance by at most delta_i. It stops at the first pixel that fails.
- R3: No arm is longer than MAX_ARM pixels (7 by default). This is the edge of the window of 2*MAX_ARM+1 pixels per side, so a uniform window gives a full region of 225 pixels.
- R4: A region is the union of the horizontal arms of all pixels on the centre's vertical arm. Each horizontal arm is anchored on the luminance of its own pixel on the vertical arm, not on the centre's luminance.
- R5: The left and right regions are built independently. For candidate d, left window column c pairs with right strip column NDISP-1-d+c of the same row. The strip is 2*MAX_ARM+NDISP columns wide, and byte index (row*width+column) holds that pixel.
- R6: The count for disparity d is the number of window positions that are inside both regions and whose left and right luminances differ by at most match_thr_i. A count never exceeds the window area.
- R7: The reported disparity has the largest count among the 60 candidates. On a tie, the lowest disparity wins.
- R8: A start_i pulse seen while idle begins a request. done_o is high for exactly one cycle, NDISP+1 cycles after the edge that accepted start. start_i is ignored while a request is running. disp_o and count_o hold their values until the next done.
- R9: disp_o is 6 bits wide and always lies in 0..59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| delta_i | input | 8 | Luminance tolerance for arm growth |
| match_thr_i | input | 8 | Luminance tolerance for a vote |
| left_win_i | input | 1800 | Left window, 15x15 pixels, row-major, 8 bits each |
| right_strip_i | input | 8880 | Right strip, 15x74 pixels, row-major, 8 bits each |
| done_o | output | 1 | One-cycle result pulse |
| disp_o | output | 6 | Winning disparity |
| count_o | output | 8 | Vote count of the winning disparity |

## Verification
The assertions check the handshake on every cycle:
- done falls one cycle after it rises;
- done appears only at the fixed distance after an accepted start;
- results stay steady between pulses;
- the reported disparity and count stay in range.

Whether a region has the right shape cannot be seen from the handshake; only the bench scenarios show it. These scenarios cover:
- an arm stopped by an edge or by a single pixel;
- a horizontal arm that passes only because it uses its own anchor;
- an intersection that clips the votes;
- ties that must resolve to the lowest disparity.

Random textures are compared against an arithmetic model of the region and vote rules.

// File: rtl/xsa_pkg.sv
`timescale 1ns/1ps
package xsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FIN
    } xsa_state_e;
endpackage

// File: rtl/xsa_arm.sv
`timescale 1ns/1ps
// Measures the two arm lengths of a line of 2*MAX_ARM+1 pixels anchored on its middle pixel.
module xsa_arm #(
    parameter int PIX_W   = 8,
    parameter int MAX_ARM = 7,
    parameter int ARM_W   = $clog2(MAX_ARM + 1)
) (
    input  logic [(2*MAX_ARM+1)*PIX_W-1:0] line_i,
    input  logic [PIX_W-1:0]               delta_i,
    output logic [ARM_W-1:0]               neg_o,
    output logic [ARM_W-1:0]               pos_o
);
    function automatic logic near(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
                                  input logic [PIX_W-1:0] t);
        logic [PIX_W-1:0] df;
        df = (a > b) ? (a - b) : (b - a);
        return (df <= t);
    endfunction

    logic [PIX_W-1:0] anchor;
    logic             run_n, run_p;
    logic [ARM_W-1:0] len_n, len_p;

    always_comb begin
        anchor = line_i[MAX_ARM*PIX_W +: PIX_W];
        run_n  = 1'b1;
        run_p  = 1'b1;
        len_n  = '0;
        len_p  = '0;
        for (int k = 1; k <= MAX_ARM; k++) begin
            if (run_n && near(line_i[(MAX_ARM-k)*PIX_W +: PIX_W], anchor, delta_i))
                len_n = len_n + ARM_W'(1);
            else
                run_n = 1'b0;
            if (run_p && near(line_i[(MAX_ARM+k)*PIX_W +: PIX_W], anchor, delta_i))
                len_p = len_p + ARM_W'(1);
            else
                run_p = 1'b0;
        end
    end

    assign neg_o = len_n;
    assign pos_o = len_p;
endmodule

// File: rtl/xsa_region.sv
`timescale 1ns/1ps
// Builds the cross-based support mask of one square window.
module xsa_region #(
    parameter int PIX_W   = 8,
    parameter int MAX_ARM = 7,
    parameter int ARM_W   = $clog2(MAX_ARM + 1),
    parameter int N       = 2*MAX_ARM + 1
) (
    input  logic [N*N*PIX_W-1:0] win_i,
    input  logic [PIX_W-1:0]     delta_i,
    output logic [N*N-1:0]       mask_o
);
    logic [N*PIX_W-1:0] col_line;
    logic [ARM_W-1:0]   up_len, dn_len;
    logic [ARM_W-1:0]   lf_len [N];
    logic [ARM_W-1:0]   rt_len [N];

    for (genvar r = 0; r < N; r++) begin : g_col
        assign col_line[r*PIX_W +: PIX_W] = win_i[(r*N + MAX_ARM)*PIX_W +: PIX_W];
    end

    xsa_arm #(.PIX_W(PIX_W), .MAX_ARM(MAX_ARM), .ARM_W(ARM_W)) u_vert (
        .line_i  (col_line),
        .delta_i (delta_i),
        .neg_o   (up_len),
        .pos_o   (dn_len)
    );

    for (genvar r = 0; r < N; r++) begin : g_row
        xsa_arm #(.PIX_W(PIX_W), .MAX_ARM(MAX_ARM), .ARM_W(ARM_W)) u_horz (
            .line_i  (win_i[r*N*PIX_W +: N*PIX_W]),
            .delta_i (delta_i),
            .neg_o   (lf_len[r]),
            .pos_o   (rt_len[r])
        );
    end

    always_comb begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                mask_o[r*N + c] = (r >= MAX_ARM - int'(up_len)) &&
                                  (r <= MAX_ARM + int'(dn_len)) &&
                                  (c >= MAX_ARM - int'(lf_len[r])) &&
                                  (c <= MAX_ARM + int'(rt_len[r]));
            end
        end
    end
endmodule

// File: rtl/xsa_argmax.sv
`timescale 1ns/1ps
// Balanced pairwise maximum over NDISP counts; the lower index wins ties.
module xsa_argmax #(
    parameter int NDISP  = 60,
    parameter int CNT_W  = 8,
    parameter int DISP_W = $clog2(NDISP)
) (
    input  logic [NDISP*CNT_W-1:0] cnt_i,
    output logic [DISP_W-1:0]      idx_o,
    output logic [CNT_W-1:0]       cnt_o
);
    localparam int NPAD = 1 << DISP_W;

    logic [CNT_W-1:0]  node_c [NPAD];
    logic [DISP_W-1:0] node_x [NPAD];

    always_comb begin
        for (int i = 0; i < NPAD; i++) begin
            node_c[i] = (i < NDISP) ? cnt_i[i*CNT_W +: CNT_W] : '0;
            node_x[i] = DISP_W'(i);
        end
        for (int l = 1; l <= DISP_W; l++) begin
            for (int k = 0; k < (NPAD >> l); k++) begin
                if (node_c[2*k+1] > node_c[2*k]) begin
                    node_c[k] = node_c[2*k+1];
                    node_x[k] = node_x[2*k+1];
                end else begin
                    node_c[k] = node_c[2*k];
                    node_x[k] = node_x[2*k];
                end
            end
        end
    end

    assign idx_o = node_x[0];
    assign cnt_o = node_c[0];
endmodule

// File: rtl/xsupport_agg.sv
`timescale 1ns/1ps
module xsupport_agg #(
    parameter int PIX_W   = 8,
    parameter int MAX_ARM = 7,
    parameter int NDISP   = 60,
    parameter int N       = 2*MAX_ARM + 1,
    parameter int SW      = 2*MAX_ARM + NDISP,
    parameter int DISP_W  = $clog2(NDISP),
    parameter int CNT_W   = $clog2(N*N + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [PIX_W-1:0]        delta_i,
    input  logic [PIX_W-1:0]        match_thr_i,
    input  logic [N*N*PIX_W-1:0]    left_win_i,
    input  logic [N*SW*PIX_W-1:0]   right_strip_i,
    output logic                    done_o,
    output logic [DISP_W-1:0]       disp_o,
    output logic [CNT_W-1:0]        count_o
);
    import xsa_pkg::*;

    localparam int NPIX  = N*N;
    localparam int ARM_W = $clog2(MAX_ARM + 1);

    typedef struct packed {
        xsa_state_e                    st;
        logic [DISP_W-1:0]             d;
        logic [NDISP-1:0][CNT_W-1:0]   cnt;
        logic                          done;
        logic [DISP_W-1:0]             disp;
        logic [CNT_W-1:0]              best;
    } agg_state_t;

    agg_state_t s_d, s_q;

    function automatic logic near(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
                                  input logic [PIX_W-1:0] t);
        logic [PIX_W-1:0] df;
        df = (a > b) ? (a - b) : (b - a);
        return (df <= t);
    endfunction

    // Right window at the candidate under test.
    logic [NPIX*PIX_W-1:0] rwin;
    always_comb begin
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                rwin[(r*N + c)*PIX_W +: PIX_W] =
                    right_strip_i[(r*SW + (NDISP-1) - int'(s_q.d) + c)*PIX_W +: PIX_W];
            end
        end
    end

    logic [NPIX-1:0] lmask, rmask;

    xsa_region #(.PIX_W(PIX_W), .MAX_ARM(MAX_ARM), .ARM_W(ARM_W), .N(N)) u_lreg (
        .win_i   (left_win_i),
        .delta_i (delta_i),
        .mask_o  (lmask)
    );

    xsa_region #(.PIX_W(PIX_W), .MAX_ARM(MAX_ARM), .ARM_W(ARM_W), .N(N)) u_rreg (
        .win_i   (rwin),
        .delta_i (delta_i),
        .mask_o  (rmask)
    );

    logic [CNT_W-1:0] votes;
    always_comb begin
        votes = '0;
        for (int i = 0; i < NPIX; i++) begin
            if (lmask[i] && rmask[i] &&
                near(left_win_i[i*PIX_W +: PIX_W], rwin[i*PIX_W +: PIX_W], match_thr_i))
                votes = votes + CNT_W'(1);
        end
    end

    logic [DISP_W-1:0] win_idx;
    logic [CNT_W-1:0]  win_cnt;

    xsa_argmax #(.NDISP(NDISP), .CNT_W(CNT_W), .DISP_W(DISP_W)) u_max (
        .cnt_i (s_q.cnt),
        .idx_o (win_idx),
        .cnt_o (win_cnt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st = ST_SCAN;
                    s_d.d  = '0;
                end
            end
            ST_SCAN: begin
                s_d.cnt[s_q.d] = votes;
                if (s_q.d == DISP_W'(NDISP-1))
                    s_d.st = ST_FIN;
                else
                    s_d.d = s_q.d + DISP_W'(1);
            end
            ST_FIN: begin
                s_d.done = 1'b1;
                s_d.disp = win_idx;
                s_d.best = win_cnt;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, d: '0, cnt: '0, done: 1'b0, disp: '0, best: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o  = s_q.done;
    assign disp_o  = s_q.disp;
    assign count_o = s_q.best;
endmodule

// File: rtl/xsa_agg_chk.sv
`timescale 1ns/1ps
module xsa_agg_chk #(
    parameter int NDISP  = 60,
    parameter int DISP_W = 6,
    parameter int CNT_W  = 8,
    parameter int NPIX   = 225
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic [DISP_W-1:0] disp_o,
    input logic [CNT_W-1:0]  count_o
);
    localparam int CYC_W = $clog2(NDISP + 3);

    logic             busy_q;
    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cyc_q  <= '0;
            end
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else begin
            cyc_q <= cyc_q + CYC_W'(1);
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && cyc_q == CYC_W'(NDISP + 1)));                 // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(disp_o) && $stable(count_o)));                 // R8
    AST_DISP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (disp_o < DISP_W'(NDISP)));                              // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(count_o) <= NPIX));                                // R6
endmodule

bind xsupport_agg xsa_agg_chk #(
    .NDISP  (NDISP),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W),
    .NPIX   (N*N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .disp_o  (disp_o),
    .count_o (count_o)
);

// File: tb/xsupport_agg_tb.sv
`timescale 1ns/1ps
module xsupport_agg_tb;
    localparam int PIX_W = 8;
    localparam int R     = 7;
    localparam int ND    = 60;
    localparam int N     = 2*R + 1;
    localparam int SW    = 2*R + ND;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [PIX_W-1:0]       delta = '0;
    logic [PIX_W-1:0]       thr = '0;
    logic [N*N*PIX_W-1:0]   left_win = '0;
    logic [N*SW*PIX_W-1:0]  right_strip = '0;
    logic                   done;
    logic [5:0]             disp;
    logic [7:0]             count;

    int lw [N][N];
    int rs [N][SW];
    int ntot = 0;
    int nbad = 0;
    int seed = 1;

    always #2 clk = ~clk;

    xsupport_agg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .delta_i       (delta),
        .match_thr_i   (thr),
        .left_win_i    (left_win),
        .right_strip_i (right_strip),
        .done_o        (done),
        .disp_o        (disp),
        .count_o       (count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        ntot++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32767;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int pxl(input bit rgt, input int d, input int r, input int c);
        return rgt ? rs[r][ND-1-d+c] : lw[r][c];
    endfunction

    function automatic int arm(input bit rgt, input int d, input int r, input int c,
                               input int dr, input int dc);
        int a, n;
        a = pxl(rgt, d, r, c);
        n = 0;
        for (int k = 1; k <= R; k++) begin
            if (iabs(pxl(rgt, d, r + dr*k, c + dc*k) - a) > int'(delta)) break;
            n++;
        end
        return n;
    endfunction

    function automatic bit inreg(input bit rgt, input int d, input int r, input int c);
        int up, dn, lf, rt;
        up = arm(rgt, d, R, R, -1, 0);
        dn = arm(rgt, d, R, R, 1, 0);
        if (r < R - up || r > R + dn) return 1'b0;
        lf = arm(rgt, d, r, R, 0, -1);
        rt = arm(rgt, d, r, R, 0, 1);
        return (c >= R - lf) && (c <= R + rt);
    endfunction

    task automatic model(output int bd, output int bc);
        int v;
        bd = 0;
        bc = -1;
        for (int d = 0; d < ND; d++) begin
            v = 0;
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    if (inreg(1'b0, d, r, c) && inreg(1'b1, d, r, c) &&
                        iabs(lw[r][c] - rs[r][ND-1-d+c]) <= int'(thr))
                        v++;
            if (v > bc) begin
                bc = v;
                bd = d;
            end
        end
    endtask

    task automatic pack();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                left_win[(r*N + c)*PIX_W +: PIX_W] = lw[r][c][PIX_W-1:0];
        for (int r = 0; r < N; r++)
            for (int j = 0; j < SW; j++)
                right_strip[(r*SW + j)*PIX_W +: PIX_W] = rs[r][j][PIX_W-1:0];
    endtask

    task automatic fill(input int lv, input int rv);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) lw[r][c] = lv;
            for (int j = 0; j < SW; j++) rs[r][j] = rv;
        end
    endtask

    task automatic run(input string tag, input string req, input int exp_d, input int exp_c,
                       input bit poke);
        int n;
        int hd, hc;
        pack();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (poke && n == 10);
        end
        start = 1'b0;
        chk("R8", {tag, " done latency"}, n, ND + 1);
        chk(req, {tag, " disparity"}, int'(disp), exp_d);
        chk(req, {tag, " count"}, int'(count), exp_c);
        hd = int'(disp);
        hc = int'(count);
        repeat (poke ? 80 : 5) begin
            @(negedge clk);
            if (done) chk("R8", {tag, " spurious done"}, 1, 0);
        end
        chk("R8", {tag, " disparity held"}, int'(disp), hd);
        chk("R8", {tag, " count held"}, int'(count), hc);
    endtask

    task automatic rand_case(input string tag, input int sd, input int dl, input int th,
                             input int base, input int span, input int copy_d, input bit poke);
        int ed, ec;
        seed = sd;
        delta = PIX_W'(dl);
        thr = PIX_W'(th);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) lw[r][c] = base + rnd() % span;
            for (int j = 0; j < SW; j++) rs[r][j] = base + rnd() % span;
        end
        if (copy_d >= 0)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) rs[r][ND-1-copy_d+c] = lw[r][c];
        model(ed, ec);
        run(tag, "R6/R7", ed, ec, poke);
    endtask

    initial begin
        #600000;
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset disparity", int'(disp), 0);
        chk("R1", "reset count", int'(count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle done", int'(done), 0);

        // Flat images: full capped regions, every candidate ties.
        fill(100, 100);
        delta = 8'd0;
        thr = 8'd0;
        run("flat", "R3/R7", 0, 225, 1'b0);

        // R2: luminance step at column R+3 cuts the right arms of the left region.
        fill(80, 80);
        for (int r = 0; r < N; r++)
            for (int c = R + 3; c < N; c++) lw[r][c] = 160;
        delta = 8'd20;
        thr = 8'd255;
        run("left step", "R2", 0, 150, 1'b0);

        // R4: one pixel two rows above the centre ends the vertical arm, including rows beyond it.
        fill(80, 80);
        lw[R-2][R] = 200;
        delta = 8'd20;
        thr = 8'd255;
        run("vertical block", "R4", 0, 135, 1'b0);

        // R4: a row anchored on its own pixel keeps its full arm.
        fill(100, 100);
        for (int c = 0; c < N; c++) lw[10][c] = (c < R) ? 170 : 100;
        lw[10][R] = 135;
        delta = 8'd40;
        thr = 8'd255;
        run("own anchor", "R4", 0, 225, 1'b0);

        // R5/R6/R7: right block meets the left region cut; the tie over 14..19 goes to 14.
        fill(50, 255);
        for (int r = 0; r < N; r++) begin
            for (int c = R + 3; c < N; c++) lw[r][c] = 200;
            for (int j = 40; j <= 54; j++) rs[r][j] = 50;
        end
        delta = 8'd10;
        thr = 8'd10;
        run("intersection", "R5/R6/R7", 14, 150, 1'b0);

        // R5: exact copy at a mid disparity with full regions.
        seed = 7;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) lw[r][c] = rnd() % 256;
            for (int j = 0; j < SW; j++) rs[r][j] = rnd() % 256;
            for (int c = 0; c < N; c++) rs[r][ND-1-37+c] = lw[r][c];
        end
        delta = 8'd255;
        thr = 8'd0;
        run("copy 37", "R5", 37, 225, 1'b0);

        // R9: the highest disparity.
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) rs[r][c] = lw[r][c];
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) rs[r][ND-1-37+c] = (lw[r][c] + 128) % 256;
        run("copy 59", "R9", 59, 225, 1'b0);

        // Textured sweeps against the arithmetic model; the first also pokes start mid-run (R8).
        rand_case("tex a", 11, 8, 3, 60, 24, 25, 1'b1);
        rand_case("tex b", 22, 4, 2, 100, 12, -1, 1'b0);
        rand_case("tex c", 33, 20, 6, 20, 64, 5, 1'b0);
        rand_case("tex d", 44, 255, 0, 0, 256, 59, 1'b0);
        rand_case("tex e", 55, 12, 2, 90, 30, 0, 1'b0);
        rand_case("tex f", 66, 6, 5, 120, 16, -1, 1'b0);

        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule